// File: doc/BRIEF.md
# Receive Backplane Frame Offset Aligner

This block serializes received E1 time-slot bytes onto a backplane line. A one-bit data stream, a matching signaling stream and a regenerated frame-sync pulse are produced. The start of each output frame can be moved away from a reference frame pulse. The coarse shift is a whole number of time slots. An optional fine shift adds a few bits. The reference is either an external frame-pulse input or, when that input is not in use, the block's own free-running frame counter.

Bytes are fetched through a simple read port. The block presents a lane number and a slot number, and the surrounding logic returns that slot's data byte and signaling byte in the same cycle.

Two clock modes are supported. In single-rate mode one clock equals one bit period. In double-rate mode each bit period spans two clocks: a first edge and a second edge. The frame pulse is always sampled on the first edge. The outputs move on either the first or the second edge, depending on configuration.

A multiplexed mode interleaves four framer lanes slot by slot onto a single line.

The control is a phase state machine with three states:
- `ST_WAIT`: idle after reset.
- `ST_FIRST`: the first edge of a bit period.
- `ST_SECOND`: the second edge, used in double-rate mode only.

Its transitions are:
- WAIT→FIRST: start of counting in single-rate mode.
- WAIT→SECOND: start of counting in double-rate mode.
- FIRST→FIRST: next bit in single-rate mode.
- FIRST→SECOND: the second half of a double-rate bit.
- SECOND→FIRST: the next bit period.

Counting starts on a sampled frame pulse, or on the first clock after reset when no external pulse is used.

Top module: `rx_bp_aligner`

## Requirements
- R1: During reset, and afterwards while `ext_fp_en`=1 and no frame pulse has yet been sampled, `sd_out`, `sig_out` and `fs_out` are 0.
- R2: With zero offsets, bit period k after the reference (k=0 is the pulse period) carries bit position p=k mod 256.
  - The slot is s=p/8, read as `rd_lane`=0 and `rd_slot`=s.
  - `sd_out` and `sig_out` carry bit (7 - p mod 8) of `ts_byte` and of `sig_byte`, so the MSB goes first.
  - `fs_out` is 1 exactly when p=0.
- R3: A slot offset t (0..127) gives p=(k - 8t) mod frame length, so offsets beyond the frame wrap around.
- R4: In single-rate mode with `bofs_en`=1, the bit offset b (0..7) further gives p=(k - 8t - b) mod frame length. With `bofs_en`=0, b has no effect.
- R5: With `dbl_rate`=1, the bit offset is ignored even when `bofs_en`=1.
- R6: With `dbl_rate`=1, `early_upd`=0 and `pol_match`=0, each bit period is two clocks, and outputs change on the second clock of the period.
- R7: With `dbl_rate`=1 and `early_upd`=1, outputs change on the first clock of each bit period.
- R8: With `dbl_rate`=1 and `pol_match`=1, outputs change on the first clock of each bit period, whatever `early_upd` is.
- R9: A frame pulse that is present only on the second clock of a double-rate bit period is ignored.
- R10: With `mux_mode`=1, the frame is 128 slots (1024 bits). Global slot g is read as `rd_lane`=g mod 4 and `rd_slot`=g/4.
- R11: With `ext_fp_en`=0, counting starts on the first clock after reset (k=0). The count then wraps every frame, and the offsets are applied relative to that wrap.
- R12: A configuration change takes effect only at the next frame boundary (p counter back at bit 0). The rest of the current frame keeps the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backplane clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fp_in | input | 1 | External frame pulse, sampled on first edges |
| ext_fp_en | input | 1 | 1: use `fp_in` as reference; 0: free-run |
| mux_mode | input | 1 | 1: four-lane slot interleave |
| dbl_rate | input | 1 | 1: two clocks per bit period |
| early_upd | input | 1 | Double-rate: 1 selects first-edge update |
| pol_match | input | 1 | Double-rate: data/frame edge polarities equal, forces first-edge update |
| ts_ofs | input | 7 | Slot offset 0..127 |
| bofs_en | input | 1 | Enable bit offset |
| bofs | input | 3 | Bit offset 0..7 |
| rd_lane | output | 2 | Lane of the slot being read |
| rd_slot | output | 5 | Lane slot being read |
| ts_byte | input | 8 | Data byte for the requested slot |
| sig_byte | input | 8 | Signaling byte for the requested slot |
| sd_out | output | 1 | Serial data |
| sig_out | output | 1 | Serial signaling |
| fs_out | output | 1 | Regenerated frame sync |

## Verification
The hardest situations to reach are a frame pulse that lands on the second clock of a double-rate bit, and a configuration change in mid-frame. Neither of them changes anything at the moment it happens. The stimulus raises the pulse only between the first and second edges of one chosen bit and checks that the whole following stream keeps its original alignment. A second run rewrites the slot offset partway through a frame. The scoreboard expects the old offset until the counter wraps and the new offset after the wrap.

// File: rtl/rbp_pkg.sv
package rbp_pkg;
    localparam int LANES      = 4;
    localparam int SLOTS      = 32;
    localparam int BITS       = 8;
    localparam int TSO_W      = 7;
    localparam int LANE_W     = $clog2(LANES);
    localparam int SLOT_W     = $clog2(SLOTS);
    localparam int BIT_W      = $clog2(BITS);
    localparam int GS_W       = LANE_W + SLOT_W;
    localparam int PW         = GS_W + BIT_W;
    localparam int FRAME_BITS = SLOTS * BITS;

    typedef enum logic [1:0] {
        ST_WAIT   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } ph_state_t;

    typedef struct packed {
        logic             mux;
        logic             dbl;
        logic             early;
        logic             pmatch;
        logic [TSO_W-1:0] ts;
        logic             ben;
        logic [BIT_W-1:0] bofs;
    } cfg_t;
endpackage

// File: rtl/rbp_phase_fsm.sv
module rbp_phase_fsm
    import rbp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fp_in,
    input  logic            ext_fp_en,
    input  cfg_t            cfg_in,
    output ph_state_t       state_q,
    output logic            first_edge,
    output logic [PW-1:0]   cur,
    output cfg_t            cfg_now,
    output cfg_t            cfg_act,
    output logic [PW-1:0]   cnt_q
);
    ph_state_t     state_d;
    logic          start;
    logic          boundary;
    logic [PW-1:0] mask;
    logic [PW-1:0] cnt_d;

    always_comb begin
        start      = (state_q == ST_WAIT) && (fp_in || !ext_fp_en);
        first_edge = start || (state_q == ST_FIRST);
        if (start || ((state_q == ST_FIRST) && ext_fp_en && fp_in))
            cur = '0;
        else
            cur = cnt_q;
        boundary = first_edge && (cur == '0);
        cfg_now  = boundary ? cfg_in : cfg_act;
        mask     = cfg_now.mux ? '1 : PW'(FRAME_BITS - 1);
        cnt_d    = cnt_q;
        if (first_edge)
            cnt_d = (cur + 1'b1) & mask;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:   if (start) state_d = cfg_now.dbl ? ST_SECOND : ST_FIRST;
            ST_FIRST:  state_d = cfg_now.dbl ? ST_SECOND : ST_FIRST;
            ST_SECOND: state_d = ST_FIRST;
            default:   state_d = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            cnt_q   <= '0;
            cfg_act <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (boundary)
                cfg_act <= cfg_in;
        end
    end
endmodule

// File: rtl/rbp_offset.sv
module rbp_offset
    import rbp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  ph_state_t     state_q,
    input  logic          first_edge,
    input  cfg_t          cfg_now,
    input  logic [PW-1:0] cur,
    output logic [PW-1:0] pos_use,
    output logic          upd
);
    logic [PW-1:0] off;
    logic [PW-1:0] mask;
    logic [PW-1:0] pos_now;
    logic [PW-1:0] pos_q;
    logic          early;

    always_comb begin
        off = (PW'(cfg_now.ts) << BIT_W)
            + ((cfg_now.ben && !cfg_now.dbl) ? PW'(cfg_now.bofs) : '0);
        mask    = cfg_now.mux ? '1 : PW'(FRAME_BITS - 1);
        pos_now = (cur - off) & mask;
        early   = !cfg_now.dbl || cfg_now.early || cfg_now.pmatch;
        pos_use = (state_q == ST_SECOND) ? pos_q : pos_now;
        upd     = (first_edge && early) || ((state_q == ST_SECOND) && !early);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= '0;
        else if (first_edge)
            pos_q <= pos_now;
    end
endmodule

// File: rtl/rbp_slot_map.sv
module rbp_slot_map
    import rbp_pkg::*;
(
    input  logic [PW-1:0]     pos_use,
    input  logic              mux,
    output logic [LANE_W-1:0] rd_lane,
    output logic [SLOT_W-1:0] rd_slot,
    output logic [BIT_W-1:0]  bit_idx,
    output logic              pos_zero
);
    logic [GS_W-1:0] gslot;

    always_comb begin
        gslot    = pos_use[PW-1:BIT_W];
        bit_idx  = pos_use[BIT_W-1:0];
        pos_zero = (pos_use == '0);
        if (mux) begin
            rd_lane = gslot[LANE_W-1:0];
            rd_slot = gslot[GS_W-1:LANE_W];
        end else begin
            rd_lane = '0;
            rd_slot = gslot[SLOT_W-1:0];
        end
    end
endmodule

// File: rtl/rbp_shifter.sv
module rbp_shifter
    import rbp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [BITS-1:0]  ts_byte,
    input  logic [BITS-1:0]  sig_byte,
    input  logic [BIT_W-1:0] bit_idx,
    input  logic             pos_zero,
    output logic             sd_out,
    output logic             sig_out,
    output logic             fs_out
);
    logic [BIT_W-1:0] msb_sel;

    always_comb msb_sel = BIT_W'(BITS - 1) - bit_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_out  <= 1'b0;
            sig_out <= 1'b0;
            fs_out  <= 1'b0;
        end else if (upd) begin
            sd_out  <= ts_byte[msb_sel];
            sig_out <= sig_byte[msb_sel];
            fs_out  <= pos_zero;
        end
    end
endmodule

// File: rtl/rx_bp_aligner.sv
module rx_bp_aligner
    import rbp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fp_in,
    input  logic                    ext_fp_en,
    input  logic                    mux_mode,
    input  logic                    dbl_rate,
    input  logic                    early_upd,
    input  logic                    pol_match,
    input  logic [TSO_W-1:0]        ts_ofs,
    input  logic                    bofs_en,
    input  logic [BIT_W-1:0]        bofs,
    output logic [LANE_W-1:0]       rd_lane,
    output logic [SLOT_W-1:0]       rd_slot,
    input  logic [BITS-1:0]         ts_byte,
    input  logic [BITS-1:0]         sig_byte,
    output logic                    sd_out,
    output logic                    sig_out,
    output logic                    fs_out
);
    cfg_t             cfg_in;
    cfg_t             cfg_now;
    cfg_t             cfg_act;
    ph_state_t        state_q;
    logic             first_edge;
    logic [PW-1:0]    cur;
    logic [PW-1:0]    cnt_q;
    logic [PW-1:0]    pos_use;
    logic             upd;
    logic [BIT_W-1:0] bit_idx;
    logic             pos_zero;

    assign cfg_in = '{mux: mux_mode, dbl: dbl_rate, early: early_upd,
                      pmatch: pol_match, ts: ts_ofs, ben: bofs_en, bofs: bofs};

    rbp_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fp_in      (fp_in),
        .ext_fp_en  (ext_fp_en),
        .cfg_in     (cfg_in),
        .state_q    (state_q),
        .first_edge (first_edge),
        .cur        (cur),
        .cfg_now    (cfg_now),
        .cfg_act    (cfg_act),
        .cnt_q      (cnt_q)
    );

    rbp_offset u_off (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_q    (state_q),
        .first_edge (first_edge),
        .cfg_now    (cfg_now),
        .cur        (cur),
        .pos_use    (pos_use),
        .upd        (upd)
    );

    rbp_slot_map u_map (
        .pos_use  (pos_use),
        .mux      (cfg_now.mux),
        .rd_lane  (rd_lane),
        .rd_slot  (rd_slot),
        .bit_idx  (bit_idx),
        .pos_zero (pos_zero)
    );

    rbp_shifter u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (upd),
        .ts_byte  (ts_byte),
        .sig_byte (sig_byte),
        .bit_idx  (bit_idx),
        .pos_zero (pos_zero),
        .sd_out   (sd_out),
        .sig_out  (sig_out),
        .fs_out   (fs_out)
    );
endmodule

// File: rtl/rbp_aligner_chk.sv
module rbp_aligner_chk
    import rbp_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input ph_state_t     state_q,
    input logic          sd_out,
    input logic          sig_out,
    input logic          fs_out,
    input logic          ext_fp_en,
    input logic          dbl_now,
    input cfg_t          cfg_act,
    input logic [PW-1:0] cnt_q
);
    // R1
    wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> (!sd_out && !sig_out && !fs_out));

    // R2
    fs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_out && !dbl_now && (state_q == ST_FIRST)) |=> !fs_out);

    // R6
    phase_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SECOND) |=> (state_q == ST_FIRST));

    // R7
    early_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SECOND) && (cfg_act.early || cfg_act.pmatch))
        |=> $stable({sd_out, sig_out, fs_out}));

    // R11
    self_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WAIT) && !ext_fp_en) |=> (state_q != ST_WAIT));

    // R12
    cfg_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_act) |-> (cnt_q == PW'(1)));
endmodule

bind rx_bp_aligner rbp_aligner_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .sd_out    (sd_out),
    .sig_out   (sig_out),
    .fs_out    (fs_out),
    .ext_fp_en (ext_fp_en),
    .dbl_now   (cfg_now.dbl),
    .cfg_act   (cfg_act),
    .cnt_q     (cnt_q)
);

// File: tb/rx_bp_aligner_bench.sv
module rx_bp_aligner_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fp_in = 1'b0;
    logic       ext_fp_en, mux_mode, dbl_rate, early_upd, pol_match, bofs_en;
    logic [6:0] ts_ofs;
    logic [2:0] bofs;
    logic [1:0] rd_lane;
    logic [4:0] rd_slot;
    logic [7:0] ts_byte, sig_byte;
    logic       sd_out, sig_out, fs_out;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    int e_ts, e_bofs, glitch_k;
    bit e_ben, e_dbl, e_mux, e_early;

    typedef struct {
        logic [2:0] v;
        int         k;
        string      tag;
    } exp_t;
    exp_t q[$];
    event smp;

    always #4 clk = ~clk;

    function automatic logic [7:0] dfn(int l, int s);
        return 8'((s * 37 + l * 101 + 5) & 255);
    endfunction

    function automatic logic [7:0] sfn(int l, int s);
        return 8'(((s * 11) ^ (l * 77) ^ 90) & 255);
    endfunction

    assign ts_byte  = dfn(int'(rd_lane), int'(rd_slot));
    assign sig_byte = sfn(int'(rd_lane), int'(rd_slot));

    rx_bp_aligner u_rx_bp_aligner (
        .clk(clk), .rst_n(rst_n), .fp_in(fp_in), .ext_fp_en(ext_fp_en),
        .mux_mode(mux_mode), .dbl_rate(dbl_rate), .early_upd(early_upd),
        .pol_match(pol_match), .ts_ofs(ts_ofs), .bofs_en(bofs_en), .bofs(bofs),
        .rd_lane(rd_lane), .rd_slot(rd_slot), .ts_byte(ts_byte),
        .sig_byte(sig_byte), .sd_out(sd_out), .sig_out(sig_out), .fs_out(fs_out)
    );

    task automatic check(string tag, int k, logic [2:0] act, logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s k=%0d actual=%b expected=%b", tag, k, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_at(int k);
        int len, off, pos, gs, b, lane, s;
        len  = e_mux ? 1024 : 256;
        off  = e_ts * 8 + ((e_ben && !e_dbl) ? e_bofs : 0);
        pos  = (((k - off) % len) + len) % len;
        gs   = pos / 8;
        b    = 7 - (pos % 8);
        lane = e_mux ? gs % 4 : 0;
        s    = e_mux ? gs / 4 : gs;
        return {dfn(lane, s)[b], sfn(lane, s)[b], pos == 0};
    endfunction

    // Monitor: pops the expected item and compares it with the outputs.
    initial forever begin
        exp_t e;
        @(smp);
        if (q.size() > 0) begin
            e = q.pop_front();
            check(e.tag, e.k, {sd_out, sig_out, fs_out}, e.v);
        end
    end

    task automatic push(int k, string tag);
        exp_t e;
        e.v = exp_at(k);
        e.k = k;
        e.tag = tag;
        q.push_back(e);
        ->smp;
    endtask

    task automatic set_cfg(bit mux, bit dbl, bit early, bit pm, int ts,
                           bit ben, int bo, bit ext);
        mux_mode = mux; dbl_rate = dbl; early_upd = early; pol_match = pm;
        ts_ofs = 7'(ts); bofs_en = ben; bofs = 3'(bo); ext_fp_en = ext;
        e_mux = mux; e_dbl = dbl; e_ts = ts; e_ben = ben; e_bofs = bo;
        e_early = !dbl || early || pm;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        fp_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Driver: one pass per bit period, pushing the expected value after the update edge.
    task automatic run_bits(int n, int k0, bit pulse, string tag);
        for (int i = 0; i < n; i++) begin
            int k = k0 + i;
            if (i == 0 && pulse) fp_in = 1'b1;
            @(negedge clk);
            fp_in = 1'b0;
            if (e_early) push(k, tag);
            if (e_dbl) begin
                if (k == glitch_k) fp_in = 1'b1;
                @(negedge clk);
                fp_in = 1'b0;
                if (!e_early) push(k, tag);
            end
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        glitch_k = -1;
        set_cfg(0, 0, 0, 0, 0, 0, 0, 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 in reset", 0, {sd_out, sig_out, fs_out}, 3'b000);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R1 waiting", i, {sd_out, sig_out, fs_out}, 3'b000);
        end
        run_bits(256, 0, 1, "R2");

        set_cfg(0, 0, 0, 0, 5, 0, 0, 1);   do_reset(); run_bits(256, 0, 1, "R3");
        set_cfg(0, 0, 0, 0, 100, 0, 0, 1); do_reset(); run_bits(256, 0, 1, "R3 wrap");
        set_cfg(0, 0, 0, 0, 1, 1, 3, 1);   do_reset(); run_bits(256, 0, 1, "R4 on");
        set_cfg(0, 0, 0, 0, 1, 0, 5, 1);   do_reset(); run_bits(256, 0, 1, "R4 off");

        glitch_k = 40;
        set_cfg(0, 1, 0, 0, 4, 1, 5, 1);   do_reset(); run_bits(256, 0, 1, "R5 R6 R9");
        glitch_k = -1;
        set_cfg(0, 1, 1, 0, 2, 0, 0, 1);   do_reset(); run_bits(256, 0, 1, "R7");
        set_cfg(0, 1, 0, 1, 6, 0, 0, 1);   do_reset(); run_bits(256, 0, 1, "R8");
        set_cfg(1, 0, 0, 0, 9, 0, 0, 1);   do_reset(); run_bits(1024, 0, 1, "R10");
        set_cfg(0, 0, 0, 0, 3, 1, 2, 0);   do_reset(); run_bits(512, 0, 0, "R11");

        set_cfg(0, 0, 0, 0, 2, 0, 0, 1);   do_reset();
        run_bits(100, 0, 1, "R12 before");
        ts_ofs = 7'd7;
        run_bits(156, 100, 0, "R12 hold");
        e_ts = 7;
        run_bits(256, 256, 0, "R12 after");

        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule